// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block generates the word address for every cycle of a four-beat burst into a synchronous memory. A load cycle captures a base address and starts a burst. Each later cycle with the advance input high steps to the next beat. Only the two lowest address bits move. The bits above them stay where the load put them, so a burst never leaves its aligned four-word block.

A static order input picks one of two low-bit sequences. With the input low, the offset counts up from the start offset and wraps modulo 4. With the input high, the offset is the start offset XOR the beat number, which is the interleaved order that cache-line fills use. An active-high stall input freezes the whole block as if the clock edge had not happened. A deselect cycle ends any burst in progress. The address and burst-active flag are registered state, and they are valid from the cycle after the command edge.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted and after it is released, `addr` reads 0 and `burst_active` reads 0 until the first accepted command.
- R2: On an edge with `stall`=0, `deselect`=0 and `load`=1, the following cycle shows `addr` equal to `base_addr` and `burst_active`=1.
- R3: With `order_xor`=0, the two low bits of `addr` at beat k (k=0..3, counting from the load) equal (start offset + k) mod 4, where the start offset is `base_addr[1:0]`.
- R4: With `order_xor`=1, the two low bits of `addr` at beat k equal the start offset XOR k.
- R5: During a burst, `addr[16:2]` stays equal to the loaded `base_addr[16:2]` on every advance.
- R6: An advance after the fourth beat wraps the beat count to 0, so `addr` returns to the loaded start address and `burst_active` stays 1.
- R7: On an edge with `stall`=1, `addr` and `burst_active` keep their values, whatever the other inputs are.
- R8: On an edge with `stall`=0 and `deselect`=1, `burst_active` becomes 0 and `addr` keeps its value. Deselect takes priority over both load and advance.
- R9: An advance while `burst_active`=0 has no effect on `addr`.
- R10: A load during a burst restarts at beat 0 from the new `base_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| stall | input | 1 | High freezes all state for this edge |
| load | input | 1 | Start a burst at `base_addr` |
| advance | input | 1 | Step to the next beat of an active burst |
| deselect | input | 1 | End the burst in progress (highest priority) |
| order_xor | input | 1 | Static: 1 selects interleaved order, 0 selects linear order |
| base_addr | input | 17 | Word address captured on load |
| addr | output | 17 | Current word address |
| burst_active | output | 1 | A burst is in progress |

## Verification
The assertions check the edge-by-edge rules on every cycle: the freeze under stall, deselect clearing the active flag, a load landing on the base address, the upper bits holding across an advance, the linear step of plus one, and an advance while idle being ignored. Only the bench's scenarios can show the full beat sequences. These are the interleaved XOR pattern from several start offsets, the wrap back to the start after four beats, the restart when a load arrives mid-burst, and the reset state. Each of these needs a reference for the whole burst, not just a relation between one cycle and the next.

// File: rtl/burst_pkg.sv
package burst_pkg;
  // Decoded action for one clock edge, in priority order.
  typedef enum logic [1:0] {
    CMD_HOLD = 2'd0,
    CMD_END  = 2'd1,
    CMD_LOAD = 2'd2,
    CMD_STEP = 2'd3
  } burst_cmd_e;
endpackage

// File: rtl/burst_cmd_decode.sv
module burst_cmd_decode
  import burst_pkg::*;
(
  input  logic       stall,
  input  logic       deselect,
  input  logic       load,
  input  logic       advance,
  input  logic       active,
  output burst_cmd_e cmd
);
  // Priority: stall > deselect > load > advance (only while a burst runs).
  always_comb begin
    cmd = CMD_HOLD;
    if (!stall) begin
      if (deselect)               cmd = CMD_END;
      else if (load)              cmd = CMD_LOAD;
      else if (advance && active) cmd = CMD_STEP;
    end
  end
endmodule

// File: rtl/burst_beat_counter.sv
module burst_beat_counter
  import burst_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  burst_cmd_e        cmd,
  output logic [BEAT_W-1:0] beat,
  output logic              active
);
  logic [BEAT_W-1:0] beat_nxt;
  logic              active_nxt;
  logic              upd;

  always_comb begin
    beat_nxt   = beat;
    active_nxt = active;
    upd        = 1'b0;
    unique case (cmd)
      CMD_END: begin
        active_nxt = 1'b0;
        upd        = 1'b1;
      end
      CMD_LOAD: begin
        beat_nxt   = '0;
        active_nxt = 1'b1;
        upd        = 1'b1;
      end
      CMD_STEP: begin
        beat_nxt = beat + 1'b1;  // wraps modulo burst length
        upd      = 1'b1;
      end
      default: upd = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat   <= '0;
      active <= 1'b0;
    end else if (upd) begin
      beat   <= beat_nxt;
      active <= active_nxt;
    end
  end
endmodule

// File: rtl/burst_offset_map.sv
module burst_offset_map #(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start,
  input  logic [BEAT_W-1:0] beat,
  input  logic              order_xor,
  output logic [BEAT_W-1:0] offset
);
  logic [BEAT_W-1:0] lin_off;
  logic [BEAT_W-1:0] ilv_off;

  // Build the interleaved offset bit by bit.
  genvar i;
  generate
    for (i = 0; i < BEAT_W; i++) begin : g_xor
      assign ilv_off[i] = start[i] ^ beat[i];
    end
  endgenerate

  assign lin_off = start + beat;

  always_comb begin
    offset = order_xor ? ilv_off : lin_off;
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic              load,
  input  logic              advance,
  input  logic              deselect,
  input  logic              order_xor,
  input  logic [ADDR_W-1:0] base_addr,
  output logic [ADDR_W-1:0] addr,
  output logic              burst_active
);
  localparam int HI_W = ADDR_W - BEAT_W;

  burst_cmd_e        cmd;
  logic [BEAT_W-1:0] beat;
  logic [BEAT_W-1:0] offset;
  logic [HI_W-1:0]   hi_q,    hi_nxt;
  logic [BEAT_W-1:0] start_q, start_nxt;
  logic              cap;

  burst_cmd_decode u_dec (
    .stall    (stall),
    .deselect (deselect),
    .load     (load),
    .advance  (advance),
    .active   (burst_active),
    .cmd      (cmd)
  );

  burst_beat_counter #(.BEAT_W(BEAT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd    (cmd),
    .beat   (beat),
    .active (burst_active)
  );

  burst_offset_map #(.BEAT_W(BEAT_W)) u_map (
    .start     (start_q),
    .beat      (beat),
    .order_xor (order_xor),
    .offset    (offset)
  );

  // Base address capture: next-state logic.
  always_comb begin
    cap       = (cmd == CMD_LOAD);
    hi_nxt    = base_addr[ADDR_W-1:BEAT_W];
    start_nxt = base_addr[BEAT_W-1:0];
  end

  // Base address capture: registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q    <= '0;
      start_q <= '0;
    end else if (cap) begin
      hi_q    <= hi_nxt;
      start_q <= start_nxt;
    end
  end

  assign addr = {hi_q, offset};
endmodule

// File: rtl/burst_addr_gen_checker.sv
module burst_addr_gen_checker #(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stall,
  input logic              load,
  input logic              advance,
  input logic              deselect,
  input logic              order_xor,
  input logic [ADDR_W-1:0] base_addr,
  input logic [ADDR_W-1:0] addr,
  input logic              burst_active
);
  assert_stall_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(addr) && $stable(burst_active)));

  assert_deselect_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && deselect) |=> (!burst_active && $stable(addr)));

  assert_load_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !deselect && load) |=> (burst_active && addr == $past(base_addr)));

  assert_upper_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !deselect && !load && advance && burst_active)
      |=> (addr[ADDR_W-1:BEAT_W] == $past(addr[ADDR_W-1:BEAT_W])));

  assert_linear_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !deselect && !load && advance && burst_active && !order_xor)
      |=> (addr[BEAT_W-1:0] == BEAT_W'($past(addr[BEAT_W-1:0]) + 1'b1)));

  assert_idle_advance_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !deselect && !load && !burst_active) |=> ($stable(addr) && !burst_active));
endmodule

bind burst_addr_gen burst_addr_gen_checker #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .stall        (stall),
  .load         (load),
  .advance      (advance),
  .deselect     (deselect),
  .order_xor    (order_xor),
  .base_addr    (base_addr),
  .addr         (addr),
  .burst_active (burst_active)
);

// File: tb/burst_addr_gen_bench.sv
`timescale 1ns/1ps
module burst_addr_gen_bench;
  localparam int AW = 17;

  typedef struct {
    logic [AW-1:0] exp_addr;
    logic          exp_act;
    string         tag;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          stall, load, advance, deselect, order_xor;
  logic [AW-1:0] base_addr;
  logic [AW-1:0] addr;
  logic          burst_active;

  int    n_run  = 0;
  int    n_fail = 0;
  item_t sb[$];

  // Reference state
  logic [AW-1:0] m_base;
  logic [1:0]    m_beat;
  logic          m_act;

  always #2 clk = ~clk;

  burst_addr_gen u_burst_addr_gen (
    .clk (clk), .rst_n (rst_n), .stall (stall), .load (load),
    .advance (advance), .deselect (deselect), .order_xor (order_xor),
    .base_addr (base_addr), .addr (addr), .burst_active (burst_active)
  );

  function automatic logic [AW-1:0] model_addr();
    logic [1:0] off;
    off = order_xor ? (m_base[1:0] ^ m_beat) : 2'(m_base[1:0] + m_beat);
    return {m_base[AW-1:2], off};
  endfunction

  task automatic check(input logic [AW-1:0] ea, input logic eact, input string tag);
    n_run++;
    if (addr !== ea || burst_active !== eact) begin
      n_fail++;
      $display("FAIL %s: addr=%05h active=%0b expected addr=%05h active=%0b",
               tag, addr, burst_active, ea, eact);
    end
  endtask

  // Driver: apply one cycle of stimulus and queue the expected result.
  task automatic cyc(input logic st, input logic ds, input logic ld, input logic adv,
                     input logic [AW-1:0] b, input string tag);
    item_t it;
    @(negedge clk);
    stall = st; deselect = ds; load = ld; advance = adv; base_addr = b;
    if (!st) begin
      if (ds) m_act = 1'b0;
      else if (ld) begin m_base = b; m_beat = 2'd0; m_act = 1'b1; end
      else if (adv && m_act) m_beat = m_beat + 2'd1;
    end
    it.exp_addr = model_addr();
    it.exp_act  = m_act;
    it.tag      = tag;
    sb.push_back(it);
  endtask

  // Monitor: compare one queued item after each edge.
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      check(it.exp_addr, it.exp_act, it.tag);
    end
  end

  task automatic do_reset(input logic ord);
    @(negedge clk);
    rst_n = 1'b0; stall = 0; load = 0; advance = 0; deselect = 0;
    base_addr = '0; order_xor = ord;
    m_base = '0; m_beat = 2'd0; m_act = 1'b0;
    @(negedge clk);
    check('0, 1'b0, "R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check('0, 1'b0, "R1 after reset");
  endtask

  initial begin
    rst_n = 1'b0;
    // Linear order
    do_reset(1'b0);
    cyc(0, 0, 0, 1, '0, "R9 advance while idle");
    cyc(0, 0, 1, 0, 17'h12345, "R2 load base");
    for (int k = 1; k < 4; k++) cyc(0, 0, 0, 1, '0, "R3 R5 linear beat");
    cyc(0, 0, 0, 1, '0, "R6 linear wrap");
    cyc(1, 0, 1, 1, 17'h0AAAA, "R7 stall holds");
    cyc(1, 1, 0, 0, '0, "R7 stall over deselect");
    cyc(0, 0, 0, 1, '0, "R3 step after stall");
    cyc(0, 0, 1, 0, 17'h1FFFF, "R10 load mid-burst");
    cyc(0, 0, 0, 1, '0, "R10 R3 restart beat");
    cyc(0, 1, 1, 1, 17'h00004, "R8 deselect over load");
    cyc(0, 0, 0, 1, '0, "R9 advance after deselect");
    // Interleaved order
    do_reset(1'b1);
    cyc(0, 0, 1, 0, 17'h0ABC2, "R2 load interleaved");
    for (int k = 1; k < 4; k++) cyc(0, 0, 0, 1, '0, "R4 R5 interleaved beat");
    cyc(0, 0, 0, 1, '0, "R6 interleaved wrap");
    cyc(0, 0, 1, 0, 17'h00013, "R10 load start 3");
    for (int k = 1; k < 4; k++) cyc(0, 0, 0, 1, '0, "R4 interleaved start 3");
    cyc(0, 0, 0, 0, '0, "R8 idle hold");
    cyc(0, 1, 0, 1, '0, "R8 deselect over advance");
    cyc(0, 0, 0, 0, '0, "R8 stays ended");
    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #20000;
    n_run++; n_fail++;
    $display("FAIL watchdog: timeout actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule